// File: doc/BRIEF.md
# Grouped Interrupt Event Aggregator

This block keeps a register of sticky event flags for a network controller. Hardware raises a flag with a one-cycle pulse on its event input. Software lowers a flag by writing a one to its position in the event register. A separate enable mask decides which flags may interrupt.

The enabled flags are combined into three registered level interrupts. The transmit-frame interrupt covers the transmit buffer and frame flags, and the receive-frame interrupt covers the receive buffer and frame flags. Each frame interrupt is held back while its coalescing qualifier is unsatisfied. The error interrupt collects every remaining flag, which cover error, diagnostic and special events.

Flag positions are fixed:

| Bit | Flag |
|-----|------|
| 0 | transmit buffer |
| 1 | transmit frame |
| 2 | receive buffer |
| 3 | receive frame |
| 4 up to EW-1 | error group (`N_ERR` flags) |

With the default `N_ERR` of 21, EW is 25.

Top module: `irq_event_agg`

## Requirements
- R1: After reset, the event register, the mask register and all three interrupt outputs are zero.
- R2: A write with `wr_sel`=0 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A one-cycle pulse on `evt_pulse[i]` sets event bit i. The bit stays set until software clears it.
- R4: If a pulse and a software clear reach the same event bit in the same cycle, the bit ends up set.
- R5: An event bit whose mask bit is 0 drives no interrupt. The event bit can still be read back.
- R6: `irq_tx` is 1 when bit 0 or bit 1 is set and enabled, and at the same time either `tx_coal_en` is 0 or `tx_coal_hit` is 1.
- R7: `irq_rx` follows the same rule as R6, using bits 2 and 3 together with `rx_coal_en` and `rx_coal_hit`.
- R8: A frame interrupt stays asserted until both its buffer bit and its frame bit have been cleared.
- R9: `irq_err` is the OR of the enabled bits from 4 up to EW-1. It falls only when all of those bits are clear.
- R10: Each interrupt output reflects the event, mask and qualifier state one clock after that state changes.
- R11: A write with `wr_sel`=1 loads the whole mask register. `rd_sel`=1 reads the mask back, and `rd_sel`=0 reads the event register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | EW | One-cycle hardware event pulses, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the event register (write one to clear), 1 selects the mask register |
| wr_data | input | EW | Write data |
| rd_sel | input | 1 | Read source: 0 selects the event register, 1 selects the mask register |
| rd_data | output | EW | Combinational read data |
| tx_coal_en | input | 1 | Transmit coalescing enabled |
| tx_coal_hit | input | 1 | Transmit coalescing threshold reached |
| rx_coal_en | input | 1 | Receive coalescing enabled |
| rx_coal_hit | input | 1 | Receive coalescing threshold reached |
| irq_tx | output | 1 | Transmit-frame interrupt |
| irq_rx | output | 1 | Receive-frame interrupt |
| irq_err | output | 1 | Error/diagnostic/special interrupt |

## Verification
The assertions assume that the pulse, write and qualifier inputs are known values on every clock edge after reset. They also assume that the qualifier inputs may change on any cycle with no relation to the event flags. The bench drives every input to zero from time zero. It changes inputs only a short time after a rising edge, so each value is steady for a whole cycle. It holds the qualifiers constant between the moment a flag is pulsed and the moment the output is sampled, which keeps the one-cycle relation of R10 observable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   // Flag positions: the grouping logic decodes these, so they are fixed
   localparam int TXB_BIT  = 0;
   localparam int TXF_BIT  = 1;
   localparam int RXB_BIT  = 2;
   localparam int RXF_BIT  = 3;
   localparam int ERR_BASE = 4;

   typedef enum logic {
      SEL_EVENT = 1'b0,
      SEL_MASK  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_evt_latch: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[b] <= 1'b0;
         else if (set_i[b]) q_o[b] <= 1'b1;   // a set beats a clear
         else if (clr_i[b]) q_o[b] <= 1'b0;
      end
   end

   // R2
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(clr_i & ~set_i) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
   // R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |set_i |=> ((q_o & $past(set_i)) == $past(set_i)));
   // R4
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(set_i & clr_i) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   // R11
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/irq_frame_gate.sv
module irq_frame_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic buf_act_i,
   input  logic frm_act_i,
   input  logic coal_en_i,
   input  logic coal_hit_i,
   output logic irq_o
);
   logic qual_ok;
   assign qual_ok = !coal_en_i || coal_hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= (buf_act_i || frm_act_i) && qual_ok;
   end

   // R6
   coal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coal_en_i && !coal_hit_i) |=> !irq_o);
   // R8
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_act_i || frm_act_i) && !coal_en_i) |=> irq_o);
   // R10
   frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_act_i && !frm_act_i) |=> !irq_o);
endmodule

// File: rtl/irq_err_reduce.sv
module irq_err_reduce #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] act_i,
   output logic         irq_o
);
   logic any_act;

   if (W == 1) begin : g_single
      assign any_act = act_i[0];
   end else begin : g_multi
      assign any_act = |act_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_act;
   end

   // R9
   err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i != '0) |=> irq_o);
   // R9
   err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == '0) |=> !irq_o);
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
   import irq_agg_pkg::*;
#(
   parameter int N_ERR = 21,
   localparam int EW   = ERR_BASE + N_ERR
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] evt_pulse,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [EW-1:0] wr_data,
   input  logic          rd_sel,
   output logic [EW-1:0] rd_data,
   input  logic          tx_coal_en,
   input  logic          tx_coal_hit,
   input  logic          rx_coal_en,
   input  logic          rx_coal_hit,
   output logic          irq_tx,
   output logic          irq_rx,
   output logic          irq_err
);
   if (N_ERR < 1) begin : g_bad_nerr
      $error("irq_event_agg: N_ERR must be at least 1");
   end

   logic [EW-1:0] evt_q, mask_q, clr_vec, act;
   logic          mask_we;

   assign clr_vec = (wr_en && wr_sel == logic'(SEL_EVENT)) ? wr_data : '0;
   assign mask_we = wr_en && wr_sel == logic'(SEL_MASK);
   assign act     = evt_q & mask_q;
   assign rd_data = (rd_sel == logic'(SEL_MASK)) ? mask_q : evt_q;

   irq_evt_latch #(.W(EW)) u_evt (
      .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(clr_vec), .q_o(evt_q)
   );

   irq_mask_reg #(.W(EW)) u_mask (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we), .d_i(wr_data), .q_o(mask_q)
   );

   irq_frame_gate u_tx (
      .clk(clk), .rst_n(rst_n),
      .buf_act_i(act[TXB_BIT]), .frm_act_i(act[TXF_BIT]),
      .coal_en_i(tx_coal_en), .coal_hit_i(tx_coal_hit), .irq_o(irq_tx)
   );

   irq_frame_gate u_rx (
      .clk(clk), .rst_n(rst_n),
      .buf_act_i(act[RXB_BIT]), .frm_act_i(act[RXF_BIT]),
      .coal_en_i(rx_coal_en), .coal_hit_i(rx_coal_hit), .irq_o(irq_rx)
   );

   irq_err_reduce #(.W(N_ERR)) u_err (
      .clk(clk), .rst_n(rst_n), .act_i(act[EW-1:ERR_BASE]), .irq_o(irq_err)
   );

   // R5
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> (!irq_tx && !irq_rx && !irq_err));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (evt_q == '0 && mask_q == '0 && !irq_tx && !irq_rx && !irq_err));
endmodule

// File: tb/irq_event_agg_bench.sv
module irq_event_agg_bench;
   localparam int EW = 25;
   localparam logic [EW-1:0] ALL = {EW{1'b1}};

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [EW-1:0] evt_pulse = '0, wr_data = '0, rd_data;
   logic          wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic          tx_coal_en = 1'b0, tx_coal_hit = 1'b0;
   logic          rx_coal_en = 1'b0, rx_coal_hit = 1'b0;
   logic          irq_tx, irq_rx, irq_err;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   irq_event_agg u_irq_event_agg (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .tx_coal_en(tx_coal_en), .tx_coal_hit(tx_coal_hit),
      .rx_coal_en(rx_coal_en), .rx_coal_hit(rx_coal_hit),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   // coal = {tx_en, tx_hit, rx_en, rx_hit}; expo = {tx, rx, err}
   typedef struct packed {
      logic [EW-1:0] evt;
      logic [EW-1:0] msk;
      logic [3:0]    coal;
      logic [2:0]    expo;
   } vec_t;

   localparam vec_t VT [11] = '{
      '{25'h0000001, 25'h0000001, 4'b0000, 3'b100},  // R6 coalescing off
      '{25'h0000002, 25'h0000002, 4'b1000, 3'b000},  // R6 threshold not met
      '{25'h0000002, 25'h0000002, 4'b1100, 3'b100},  // R6 threshold met
      '{25'h0000001, 25'h0000000, 4'b0000, 3'b000},  // R5 masked
      '{25'h0000004, 25'h0000004, 4'b0000, 3'b010},  // R7 coalescing off
      '{25'h0000008, 25'h0000008, 4'b0010, 3'b000},  // R7 threshold not met
      '{25'h0000008, 25'h000000C, 4'b0011, 3'b010},  // R7 threshold met
      '{25'h0000010, 25'h0000010, 4'b0000, 3'b001},  // R9 lowest error bit
      '{25'h1000000, 25'h1000000, 4'b0000, 3'b001},  // R9 highest error bit
      '{25'h1000000, 25'h0800000, 4'b0000, 3'b000},  // R5 other bit enabled
      '{25'h000000F, ALL,         4'b1000, 3'b010}   // R6 R7 mixed
   };

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [EW-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [EW-1:0] p);
      evt_pulse = p;
      step();
      evt_pulse = '0;
   endtask

   function automatic logic [31:0] irqs();
      return {29'd0, irq_tx, irq_rx, irq_err};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #35; rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 irqs", irqs(), 0);
      rd_sel = 1'b0; #1; check("R1 events", 32'(rd_data), 0);
      rd_sel = 1'b1; #1; check("R1 mask", 32'(rd_data), 0);

      // vector walk
      foreach (VT[i]) begin
         wr(1'b0, ALL);
         wr(1'b1, VT[i].msk);
         {tx_coal_en, tx_coal_hit, rx_coal_en, rx_coal_hit} = VT[i].coal;
         pulse(VT[i].evt);
         step();
         check($sformatf("R6/R7/R9/R5 vector %0d irq", i), irqs(), 32'(VT[i].expo));
         rd_sel = 1'b0; #1;
         check($sformatf("R3 vector %0d events", i), 32'(rd_data), 32'(VT[i].evt));
      end
      {tx_coal_en, tx_coal_hit, rx_coal_en, rx_coal_hit} = 4'b0000;

      // R11 mask readback
      wr(1'b1, 25'h1A5A5A5);
      rd_sel = 1'b1; #1; check("R11 mask readback", 32'(rd_data), 32'h1A5A5A5);

      // R2 write-one-to-clear, zero writes ignored
      wr(1'b0, ALL); wr(1'b1, '0);
      pulse(25'h000001F);
      wr(1'b0, 25'h0000001);
      rd_sel = 1'b0; #1; check("R2 clear one bit", 32'(rd_data), 32'h1E);
      wr(1'b0, 25'h0000000);
      #1; check("R2 zero write no effect", 32'(rd_data), 32'h1E);

      // R4 set beats clear in the same cycle
      wr(1'b0, ALL);
      evt_pulse = 25'h0000020; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 25'h0000020;
      step();
      evt_pulse = '0; wr_en = 1'b0; wr_data = '0;
      #1; check("R4 set wins", 32'(rd_data), 32'h20);

      // R10 one-cycle latency
      wr(1'b0, ALL); wr(1'b1, ALL); step();
      pulse(25'h0000040);
      check("R10 not yet", 32'(irq_err), 0);
      step();
      check("R10 after one cycle", 32'(irq_err), 1);

      // R8 frame interrupt held until both bits cleared
      wr(1'b0, ALL);
      pulse(25'h0000003);
      step();
      check("R8 tx up", 32'(irq_tx), 1);
      wr(1'b0, 25'h0000001); step();
      check("R8 tx held with frame bit set", 32'(irq_tx), 1);
      wr(1'b0, 25'h0000002); step();
      check("R8 tx released", 32'(irq_tx), 0);

      // R9 error drops only when all error bits clear
      pulse(25'h0000300);
      step();
      wr(1'b0, 25'h0000100); step();
      check("R9 err held", 32'(irq_err), 1);
      wr(1'b0, 25'h0000200); step();
      check("R9 err released", 32'(irq_err), 0);

      finish_run();
   end
endmodule